// File: doc/BRIEF.md
# Bridge Legacy Video Forwarding Decoder

This block sits on the upstream side of a bridge. For each transaction it decides whether the bridge should positively decode the transaction and pass it downstream to the legacy video resources. Those resources are three fixed ranges: the video memory window and two video I/O port groups. The fixed ranges are claimed on their own terms. They do not consult any programmed forwarding window, so a claim here overrides whatever those windows would have decided.

Two configuration registers control the block. Both are held inside the block and are written through a simple dword-indexed write port with byte enables:

- The 16-bit command register gives the I/O-space enable and the memory-space enable.
- The 16-bit bridge control register gives the legacy video enable.

The decode result is combinational from the transaction inputs and the registered enables. A configuration write is therefore reflected in the decode from the first cycle after its clock edge.

The transaction kind is selected with `unique case` on an enumerated kind (memory or I/O). The only sequential state is the three registered enable bits. There is no state machine: the block has no states or transitions to name.

Top module: `vga_fwd_decoder`

## Requirements
- R1: A memory transaction (`txn_kind`=0) is claimed with `fwd_range`=1 when its 32-bit address lies in 0x000A0000..0x000BFFFF inclusive and the enables of R4 and R5 allow it. Addresses 0x0009FFFF and 0x000C0000 are not claimed.
- R2: An I/O transaction (`txn_kind`=1) at a port in 0x3B0..0x3BB inclusive is claimed with `fwd_range`=2. Ports 0x3AF and 0x3BC..0x3BF are not claimed.
- R3: An I/O transaction at a port in 0x3C0..0x3DF inclusive is claimed with `fwd_range`=3. Port 0x3E0 is not claimed.
- R4: While the legacy video enable (bridge control register bit 3) is 0, no transaction is claimed.
- R5: A memory claim additionally requires command bit 1 (memory-space enable). An I/O claim additionally requires command bit 0 (I/O-space enable). Neither bit affects the other kind.
- R6: The compare uses the full address. Any address with a nonzero bit above bit 15 (I/O) or above bit 19 outside the window (memory) is not claimed. For example, I/O port 0x13B0 and memory address 0x100A0000 do not hit.
- R7: `fwd_hit` is 1 exactly when `fwd_range` is nonzero, and both are 0 whenever `txn_valid` is 0.
- R8: A configuration write to dword index 1 updates command bytes 0 and 1 from data lanes 0 and 1. A write to dword index 15 updates bridge control bytes 0 and 1 from data lanes 2 and 3, so the video enable is `cfg_wdata` bit 19. Only lanes whose byte enable is set are written. During the write cycle the decode still uses the old enables; from the next cycle it uses the new ones.
- R9: After reset both registers are zero, so nothing is claimed.
- R10: Writes to any other dword index, or through lanes outside a register, leave all enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw | input | 6 | Dword index of the configuration write |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| txn_valid | input | 1 | Transaction present on the upstream side |
| txn_kind | input | 1 | 0 = memory, 1 = I/O |
| txn_addr | input | 32 | Transaction address |
| fwd_hit | output | 1 | Transaction claimed for downstream forwarding |
| fwd_range | output | 2 | 0 none, 1 video memory, 2 low port group, 3 high port group |

## Verification
A configuration write to the bridge control register and the decode of a legacy address can fall in the same cycle. The bench provokes this by holding an I/O transaction at port 0x3C5 steady while it writes the video enable on and then off again. In the write cycle, before the edge, it judges the outcome against the old enable. After the edge it judges the outcome against the new one. Sweeps over all 8192 ports below 0x2000 and over the region around the memory window, under all four command settings, compare every output against an arithmetic model.

// File: rtl/vga_fwd_pkg.sv
package vga_fwd_pkg;

    localparam int ADDR_W = 32;
    localparam int IO_W   = 16;

    localparam logic [ADDR_W-1:0] VMEM_BASE  = 32'h000A_0000;
    localparam logic [ADDR_W-1:0] VMEM_SPAN  = 32'h0002_0000;
    localparam logic [IO_W-1:0]   PORT_LO_BASE = 16'h03B0;
    localparam logic [IO_W-1:0]   PORT_LO_SPAN = 16'h000C;
    localparam logic [IO_W-1:0]   PORT_HI_BASE = 16'h03C0;
    localparam logic [IO_W-1:0]   PORT_HI_SPAN = 16'h0020;

    typedef enum logic [1:0] {
        RANGE_NONE  = 2'd0,
        RANGE_MEM   = 2'd1,
        RANGE_IO_LO = 2'd2,
        RANGE_IO_HI = 2'd3
    } vga_range_e;

    typedef enum logic {
        KIND_MEM = 1'b0,
        KIND_IO  = 1'b1
    } txn_kind_e;

    typedef struct packed {
        logic vid_en;
        logic mem_en;
        logic io_en;
    } fwd_enables_t;

endpackage

// File: rtl/vga_cfg_bit.sv
module vga_cfg_bit #(
    parameter int DW_W    = 6,
    parameter int REG_DW  = 1,
    parameter int LANE0   = 0,
    parameter int BIT_POS = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [DW_W-1:0] cfg_dw,
    input  logic [3:0]      cfg_be,
    input  logic [31:0]     cfg_wdata,
    output logic            bit_q
);

    localparam int DATA_BIT = LANE0 * 8 + BIT_POS;
    localparam int BE_IDX   = DATA_BIT / 8;

    logic wr_sel;
    assign wr_sel = cfg_wr && (cfg_dw == DW_W'(REG_DW)) && cfg_be[BE_IDX];

    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_q <= 1'b0;
        else if (wr_sel)
            bit_q <= cfg_wdata[DATA_BIT];
    end

endmodule

// File: rtl/vga_cfg_regs.sv
module vga_cfg_regs
    import vga_fwd_pkg::*;
#(
    parameter int DW_W       = 6,
    parameter int CMD_DW     = 1,
    parameter int CMD_LANE   = 0,
    parameter int CTL_DW     = 15,
    parameter int CTL_LANE   = 2,
    parameter int IO_EN_BIT  = 0,
    parameter int MEM_EN_BIT = 1,
    parameter int VID_EN_BIT = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [DW_W-1:0] cfg_dw,
    input  logic [3:0]      cfg_be,
    input  logic [31:0]     cfg_wdata,
    output fwd_enables_t    en
);

    vga_cfg_bit #(.DW_W(DW_W), .REG_DW(CMD_DW), .LANE0(CMD_LANE), .BIT_POS(IO_EN_BIT)) i_io_en (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .bit_q(en.io_en)
    );

    vga_cfg_bit #(.DW_W(DW_W), .REG_DW(CMD_DW), .LANE0(CMD_LANE), .BIT_POS(MEM_EN_BIT)) i_mem_en (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .bit_q(en.mem_en)
    );

    vga_cfg_bit #(.DW_W(DW_W), .REG_DW(CTL_DW), .LANE0(CTL_LANE), .BIT_POS(VID_EN_BIT)) i_vid_en (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .bit_q(en.vid_en)
    );

endmodule

// File: rtl/vga_range_match.sv
module vga_range_match
    import vga_fwd_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int IOW = IO_W
) (
    input  logic [AW-1:0] addr,
    output logic          in_vmem,
    output logic          in_port_lo,
    output logic          in_port_hi
);

    localparam logic [AW-1:0]  VMEM_LAST    = VMEM_BASE + VMEM_SPAN - 1'b1;
    localparam logic [IOW-1:0] PORT_LO_LAST = PORT_LO_BASE + PORT_LO_SPAN - 1'b1;
    localparam logic [IOW-1:0] PORT_HI_LAST = PORT_HI_BASE + PORT_HI_SPAN - 1'b1;

    logic           upper_clear;
    logic [IOW-1:0] port;

    assign upper_clear = (addr[AW-1:IOW] == '0);
    assign port        = addr[IOW-1:0];

    always_comb begin
        in_vmem    = (addr >= VMEM_BASE) && (addr <= VMEM_LAST);
        in_port_lo = upper_clear && (port >= PORT_LO_BASE) && (port <= PORT_LO_LAST);
        in_port_hi = upper_clear && (port >= PORT_HI_BASE) && (port <= PORT_HI_LAST);
    end

endmodule

// File: rtl/vga_fwd_decoder.sv
module vga_fwd_decoder
    import vga_fwd_pkg::*;
#(
    parameter int DW_W   = 6,
    parameter int CMD_DW = 1,
    parameter int CTL_DW = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [DW_W-1:0]   cfg_dw,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    input  logic              txn_valid,
    input  logic              txn_kind,
    input  logic [ADDR_W-1:0] txn_addr,
    output logic              fwd_hit,
    output logic [1:0]        fwd_range
);

    localparam int CTL_LANE   = 2;
    localparam int VID_EN_BIT = 3;
    localparam int VID_DATA   = CTL_LANE * 8 + VID_EN_BIT;

    fwd_enables_t en;
    logic         in_vmem, in_port_lo, in_port_hi;
    vga_range_e   sel;

    vga_cfg_regs #(
        .DW_W(DW_W), .CMD_DW(CMD_DW), .CMD_LANE(0),
        .CTL_DW(CTL_DW), .CTL_LANE(CTL_LANE),
        .IO_EN_BIT(0), .MEM_EN_BIT(1), .VID_EN_BIT(VID_EN_BIT)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .en(en)
    );

    vga_range_match #(.AW(ADDR_W), .IOW(IO_W)) i_match (
        .addr(txn_addr), .in_vmem(in_vmem),
        .in_port_lo(in_port_lo), .in_port_hi(in_port_hi)
    );

    always_comb begin
        sel = RANGE_NONE;
        if (txn_valid && en.vid_en) begin
            unique case (txn_kind_e'(txn_kind))
                KIND_MEM: begin
                    if (en.mem_en && in_vmem)
                        sel = RANGE_MEM;
                end
                KIND_IO: begin
                    if (en.io_en && in_port_lo)
                        sel = RANGE_IO_LO;
                    else if (en.io_en && in_port_hi)
                        sel = RANGE_IO_HI;
                end
                default: sel = RANGE_NONE;
            endcase
        end
    end

    assign fwd_range = sel;
    assign fwd_hit   = (sel != RANGE_NONE);

    // R4
    property vid_gate_p;
        @(posedge clk) disable iff (!rst_n) fwd_hit |-> en.vid_en;
    endproperty
    vid_gate_chk: assert property (vid_gate_p);

    // R5
    property mem_gate_p;
        @(posedge clk) disable iff (!rst_n)
            (fwd_range == 2'd1) |-> (en.mem_en && !txn_kind && in_vmem);
    endproperty
    mem_gate_chk: assert property (mem_gate_p);

    // R5
    property io_gate_p;
        @(posedge clk) disable iff (!rst_n)
            (fwd_range[1]) |-> (en.io_en && txn_kind && (txn_addr[ADDR_W-1:IO_W] == '0));
    endproperty
    io_gate_chk: assert property (io_gate_p);

    // R7
    property idle_p;
        @(posedge clk) disable iff (!rst_n) !txn_valid |-> (!fwd_hit && fwd_range == 2'd0);
    endproperty
    idle_chk: assert property (idle_p);

    // R2
    property ranges_disjoint_p;
        @(posedge clk) disable iff (!rst_n) $onehot0({in_vmem && !txn_kind, in_port_lo, in_port_hi});
    endproperty
    ranges_disjoint_chk: assert property (ranges_disjoint_p);

    // R8
    property vid_off_write_p;
        @(posedge clk) disable iff (!rst_n)
            (cfg_wr && cfg_dw == DW_W'(CTL_DW) && cfg_be[CTL_LANE] && !cfg_wdata[VID_DATA]) |=> !fwd_hit;
    endproperty
    vid_off_write_chk: assert property (vid_off_write_p);

    // R9
    property reset_clear_p;
        @(posedge clk) $rose(rst_n) |-> (en == '0);
    endproperty
    reset_clear_chk: assert property (reset_clear_p);

endmodule

// File: tb/test_vga_fwd_decoder.sv
module test_vga_fwd_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_dw = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic        txn_valid = 1'b0;
    logic        txn_kind = 1'b0;
    logic [31:0] txn_addr = '0;
    logic        fwd_hit;
    logic [1:0]  fwd_range;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    logic [15:0] m_cmd = '0;
    logic [15:0] m_ctl = '0;

    always #5 clk = ~clk;

    vga_fwd_decoder i_vga_fwd_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .txn_valid(txn_valid),
        .txn_kind(txn_kind), .txn_addr(txn_addr),
        .fwd_hit(fwd_hit), .fwd_range(fwd_range)
    );

    function automatic logic [1:0] exp_range(input logic v, input logic k, input logic [31:0] a);
        if (!v || !m_ctl[3]) return 2'd0;
        if (!k) begin
            if (m_cmd[1] && a >= 32'h000A0000 && a <= 32'h000BFFFF) return 2'd1;
        end else if (m_cmd[0] && a[31:16] == 16'h0) begin
            if (a[15:0] >= 16'h03B0 && a[15:0] <= 16'h03BB) return 2'd2;
            if (a[15:0] >= 16'h03C0 && a[15:0] <= 16'h03DF) return 2'd3;
        end
        return 2'd0;
    endfunction

    task automatic check(input string tag);
        logic [1:0] e;
        e = exp_range(txn_valid, txn_kind, txn_addr);
        n_tests++;
        if (fwd_range !== e || fwd_hit !== (e != 2'd0)) begin
            n_fail++;
            $display("FAIL %s kind=%0d addr=%h cmd=%h ctl=%h: hit=%b range=%0d expected hit=%b range=%0d",
                     tag, txn_kind, txn_addr, m_cmd, m_ctl, fwd_hit, fwd_range, (e != 2'd0), e);
        end
    endtask

    task automatic probe(input logic k, input logic [31:0] a, input string tag);
        txn_valid = 1'b1;
        txn_kind  = k;
        txn_addr  = a;
        #1;
        check(tag);
    endtask

    task automatic cfg_write(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
        if (dw == 6'd1) begin
            if (be[0]) m_cmd[7:0]  = d[7:0];
            if (be[1]) m_cmd[15:8] = d[15:8];
        end else if (dw == 6'd15) begin
            if (be[2]) m_ctl[7:0]  = d[23:16];
            if (be[3]) m_ctl[15:8] = d[31:24];
        end
    endtask

    function automatic string mem_tag(input logic [31:0] a);
        if (a[31:20] != 12'h0) return "R6";
        return "R1";
    endfunction

    function automatic string io_tag(input logic [31:0] a);
        if (a[15:8] >= 8'h10) return "R6";
        if (a[15:0] < 16'h03C0) return "R2";
        return "R3";
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: nothing claimed after reset, even at legacy addresses
        probe(1'b0, 32'h000A0000, "R9");
        probe(1'b1, 32'h000003B0, "R9");
        probe(1'b1, 32'h000003C0, "R9");

        // R4: command enables on, video enable still off
        cfg_write(6'd1, 4'b0011, 32'h0000_0003);
        for (int p = 16'h03A0; p < 16'h03F0; p++) probe(1'b1, 32'(p), "R4");
        probe(1'b0, 32'h000B0000, "R4");

        // R10: lane 3 only and a foreign dword leave the video enable off
        cfg_write(6'd15, 4'b1000, 32'hFFFF_FFFF);
        probe(1'b1, 32'h000003C0, "R10");
        cfg_write(6'd14, 4'b1111, 32'hFFFF_FFFF);
        probe(1'b1, 32'h000003C0, "R10");
        probe(1'b0, 32'h000A0000, "R10");

        // R8: enable video through lane 2
        cfg_write(6'd15, 4'b0100, 32'h0008_0000);
        probe(1'b0, 32'h000A0000, "R8");

        for (int c = 0; c < 4; c++) begin
            cfg_write(6'd1, 4'b0001, 32'(c));
            // R1 R5 R6: region around the memory window, plus boundaries
            for (int a = 32'h0009F000; a < 32'h000C1000; a += 32'h80)
                probe(1'b0, 32'(a), mem_tag(32'(a)));
            probe(1'b0, 32'h0009FFFF, "R1");
            probe(1'b0, 32'h000A0000, "R1");
            probe(1'b0, 32'h000BFFFF, "R1");
            probe(1'b0, 32'h000C0000, "R1");
            probe(1'b0, 32'h100A0000, "R6");
            probe(1'b0, 32'h000003B0, "R5");
            // R2 R3 R5 R6: all ports below 0x2000
            for (int p = 0; p < 16'h2000; p++)
                probe(1'b1, 32'(p), io_tag(32'(p)));
            probe(1'b1, 32'h000103C0, "R6");
            probe(1'b1, 32'h000A0000, "R5");
        end

        // R10: byte lane 1 of command must not touch bits 0 and 1 (cmd now 3)
        cfg_write(6'd1, 4'b0010, 32'h0000_0000);
        probe(1'b1, 32'h000003B5, "R10");
        probe(1'b0, 32'h000A8000, "R10");

        // R7: idle transactions never claimed
        txn_valid = 1'b0; txn_kind = 1'b1; txn_addr = 32'h3C4; #1; check("R7");
        txn_kind = 1'b0; txn_addr = 32'hA0000; #1; check("R7");

        // R8: write and decode in the same cycle
        probe(1'b1, 32'h000003C5, "R8");
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dw = 6'd15; cfg_be = 4'b0100; cfg_wdata = 32'h0;
        #1; check("R8");
        @(negedge clk);
        cfg_wr = 1'b0; m_ctl[7:0] = 8'h00;
        check("R8");
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = 32'h0008_0000;
        #1; check("R8");
        @(negedge clk);
        cfg_wr = 1'b0; m_ctl[7:0] = 8'h08;
        check("R8");

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule